// File: doc/BRIEF.md
# Down-Counting Timer Core with Update Events

This block is the counting engine of a general-purpose timer. A counter starts at an auto-reload value and steps down toward zero. A programmable prescaler divides the input clock. When the counter passes zero it reloads and raises an update event. An update event copies the software-written buffer values into the active shadow registers. It also pulses an output and can latch an update interrupt flag.

Two forced sources can raise an update event besides the underflow. One is a self-clearing software strobe and the other is an external reset strobe from a slave controller. A forced source restarts the counter and the prescaler counter on the next edge. Software can block update events while it rewrites the buffer values. It can also keep the software strobe from setting the interrupt flag. The auto-reload value is either used as soon as it is written, or held back until the next update event.

All inputs are sampled at the rising edge of `clk`. Every result is a register output, except `irq_o`, which is combinational from the flag.

Top module: `dtim_core`

## Requirements
- R1: At an edge where a prescaler tick occurs and the count is above zero, the count drops by one. At a tick with the count at zero, the count reloads (an underflow).
- R2: While counting is enabled, the counter ticks once every (P+1) clocks. P is the active prescale value. The active prescale value takes `psc_pre_i` only at an update event.
- R3: An update event is raised by an underflow, by `ug_i` = 1, or by `slave_rst_i` = 1. It makes `upd_o` high for exactly the one cycle after the edge at which the shadow registers load.
- R4: `ug_i` or `slave_rst_i` reloads the count and clears the prescaler counter at the next edge, even while `cnt_en_i` = 0. When an update event occurs, the count reloads with `arr_pre_i`.
- R5: While `upd_dis_i` = 1, no update event occurs: `upd_o` stays 0, the shadows hold and the flag is not set. An underflow or a forced source still reloads the count from the active auto-reload value and restarts the prescaler counter from 0.
- R6: While `urs_i` = 0, any update event sets `flag_o`. The flag stays set until `flag_clr_i` = 1, and a set wins over a clear in the same cycle. `irq_o` = `flag_o` AND `irq_en_i`.
- R7: While `urs_i` = 1, an update event from `ug_i` alone still pulses `upd_o` but leaves `flag_o` unchanged. Underflow and slave-reset updates still set the flag.
- R8: With `arr_buf_en_i` = 0, the active auto-reload value is `arr_pre_i` directly. With `arr_buf_en_i` = 1, it is a shadow copy that loads `arr_pre_i` only at update events.
- R9: While `cnt_en_i` = 0 and no forced source is present, the count and the prescaler counter hold their values.
- R10: After reset, the count is 0, `upd_o` = 0, `flag_o` = 0 and `irq_o` = 0, and both shadow registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Counting enable |
| arr_pre_i | input | CNT_W | Auto-reload buffer value |
| psc_pre_i | input | PSC_W | Prescale buffer value (divide by value+1) |
| arr_buf_en_i | input | 1 | 1: auto-reload applied at update events only |
| upd_dis_i | input | 1 | 1: update events suppressed |
| urs_i | input | 1 | 1: software strobe does not set the flag |
| ug_i | input | 1 | Software update strobe, one cycle |
| slave_rst_i | input | 1 | External reset strobe, one cycle |
| flag_clr_i | input | 1 | Clears the update flag |
| irq_en_i | input | 1 | Interrupt enable |
| count_o | output | CNT_W | Counter value |
| upd_o | output | 1 | Update event pulse |
| flag_o | output | 1 | Update interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Each input takes effect at the next rising edge. The count, `upd_o` and `flag_o` therefore show the result one cycle after the stimulus, and `irq_o` follows `flag_o` in the same cycle. The bench drives inputs at the falling edge. A reference model steps once per rising edge using the inputs held across that edge, so every comparison at the next falling edge covers exactly one edge of design state. The directed cases for the flag-exclusion, suppression and hold behaviours are sampled in that same cycle.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
    // cause of an update event, highest priority first
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SLAVE = 2'd1,
        SRC_UFLOW = 2'd2,
        SRC_SW    = 2'd3
    } upd_src_e;
endpackage

// File: rtl/dtim_prescaler.sv
module dtim_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en_i,
    input  logic             restart_i,
    input  logic             load_i,
    input  logic [PSC_W-1:0] psc_pre_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
        logic [PSC_W-1:0] sh;
    } psc_st_t;

    psc_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = cnt_en_i && (st_q.cnt == st_q.sh);
        if (restart_i)
            st_d.cnt = '0;
        else if (cnt_en_i)
            st_d.cnt = tick_o ? '0 : st_q.cnt + 1'b1;
        if (load_i)
            st_d.sh = psc_pre_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.sh));
    // R9
    psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_i && !restart_i |=> $stable(st_q.cnt));
endmodule

// File: rtl/dtim_counter.sv
module dtim_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             force_i,
    input  logic             upd_i,
    input  logic             arr_buf_en_i,
    input  logic [CNT_W-1:0] arr_pre_i,
    output logic             uflow_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] arr_sh;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] arr_act;

    always_comb begin
        st_d    = st_q;
        arr_act = arr_buf_en_i ? st_q.arr_sh : arr_pre_i;
        uflow_o = tick_i && (st_q.cnt == '0);
        if (force_i || uflow_o)
            st_d.cnt = upd_i ? arr_pre_i : arr_act;
        else if (tick_i)
            st_d.cnt = st_q.cnt - 1'b1;
        if (upd_i)
            st_d.arr_sh = arr_pre_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    // R1
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && (st_q.cnt != '0) && !force_i |=> st_q.cnt == $past(st_q.cnt) - 1'b1);
    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !force_i |=> $stable(st_q.cnt));
    // R4
    forced_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_i && upd_i |=> st_q.cnt == $past(arr_pre_i));
endmodule

// File: rtl/dtim_irq.sv
module dtim_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i)      flag_d = 1'b1;
        else if (clr_i) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_i && clr_i |=> !flag_q);
endmodule

// File: rtl/dtim_core.sv
module dtim_core
    import dtim_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en_i,
    input  logic [CNT_W-1:0] arr_pre_i,
    input  logic [PSC_W-1:0] psc_pre_i,
    input  logic             arr_buf_en_i,
    input  logic             upd_dis_i,
    input  logic             urs_i,
    input  logic             ug_i,
    input  logic             slave_rst_i,
    input  logic             flag_clr_i,
    input  logic             irq_en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             upd_o,
    output logic             flag_o,
    output logic             irq_o
);
    logic     tick, uflow, force_rl, upd_ev, flag_set;
    upd_src_e src;
    logic     upd_d, upd_q;

    always_comb begin
        force_rl = ug_i | slave_rst_i;
        if (slave_rst_i) src = SRC_SLAVE;
        else if (uflow)  src = SRC_UFLOW;
        else if (ug_i)   src = SRC_SW;
        else             src = SRC_NONE;
        upd_ev   = (src != SRC_NONE) && !upd_dis_i;
        flag_set = upd_ev && !(urs_i && (src == SRC_SW));
        upd_d    = upd_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= upd_d;
    end

    assign upd_o = upd_q;

    dtim_prescaler #(.PSC_W(PSC_W)) i_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en_i  (cnt_en_i),
        .restart_i (force_rl),
        .load_i    (upd_ev),
        .psc_pre_i (psc_pre_i),
        .tick_o    (tick)
    );

    dtim_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .force_i      (force_rl),
        .upd_i        (upd_ev),
        .arr_buf_en_i (arr_buf_en_i),
        .arr_pre_i    (arr_pre_i),
        .uflow_o      (uflow),
        .count_o      (count_o)
    );

    dtim_irq i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (flag_set),
        .clr_i    (flag_clr_i),
        .irq_en_i (irq_en_i),
        .flag_o   (flag_o),
        .irq_o    (irq_o)
    );

    // R5
    dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_dis_i |=> !upd_q);
    // R3
    sw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ug_i && !upd_dis_i |=> upd_q);
endmodule

// File: tb/test_dtim_core.sv
module test_dtim_core;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en = 0, arr_buf_en = 0, upd_dis = 0, urs = 0;
    logic          ug = 0, slave_rst = 0, flag_clr = 0, irq_en = 0;
    logic [CW-1:0] arr_pre = '0;
    logic [PW-1:0] psc_pre = '0;
    logic [CW-1:0] count;
    logic          upd, flag, irq;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [CW-1:0] m_cnt, m_arrsh;
    logic [PW-1:0] m_psc, m_pscsh;
    logic          m_upd, m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtim_core #(.CNT_W(CW), .PSC_W(PW)) i_dtim_core (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .arr_pre_i(arr_pre),
        .psc_pre_i(psc_pre), .arr_buf_en_i(arr_buf_en), .upd_dis_i(upd_dis),
        .urs_i(urs), .ug_i(ug), .slave_rst_i(slave_rst), .flag_clr_i(flag_clr),
        .irq_en_i(irq_en), .count_o(count), .upd_o(upd), .flag_o(flag), .irq_o(irq)
    );

    // model one rising edge from the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = '0; m_arrsh = '0; m_psc = '0; m_pscsh = '0;
            m_upd = 1'b0; m_flag = 1'b0;
        end else begin
            logic          tk, uf, frc, up, st;
            logic [CW-1:0] act;
            tk  = cnt_en && (m_psc == m_pscsh);           // R2
            uf  = tk && (m_cnt == '0);                    // R1
            frc = ug || slave_rst;                        // R4
            up  = (uf || frc) && !upd_dis;                // R3 R5
            st  = up && (!urs || uf || slave_rst);        // R6 R7
            act = arr_buf_en ? m_arrsh : arr_pre;         // R8
            if (uf || frc)   m_cnt = up ? arr_pre : act;
            else if (tk)     m_cnt = m_cnt - 1'b1;
            if (frc)         m_psc = '0;
            else if (cnt_en) m_psc = tk ? '0 : m_psc + 1'b1;
            if (up) begin m_arrsh = arr_pre; m_pscsh = psc_pre; end
            m_upd = up;
            if (st) m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R1,R4,R8,R9 count", 32'(count), 32'(m_cnt));
        chk("R3,R5 upd_o", 32'(upd), 32'(m_upd));
        chk("R6,R7 flag_o", 32'(flag), 32'(m_flag));
        chk("R6 irq_o", 32'(irq), 32'(m_flag & irq_en));
    endtask

    task automatic quiet();
        ug = 0; slave_rst = 0; flag_clr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 count", 32'(count), 0);
        chk("R10 upd", 32'(upd), 0);
        chk("R10 flag", 32'(flag), 0);
        rst_n = 1'b1;

        // R8 unbuffered: value used at once on underflow
        arr_pre = 16'd5; psc_pre = 0; cnt_en = 1;
        @(negedge clk); cmp_all();
        chk("R8 immediate reload", 32'(count), 5);
        // R1 decrement
        @(negedge clk); cmp_all();
        chk("R1 decrement", 32'(count), 4);

        // R9 hold
        cnt_en = 0;
        repeat (3) begin @(negedge clk); cmp_all(); end
        chk("R9 hold", 32'(count), 4);

        // R7 flag exclusion of the software strobe
        flag_clr = 1; @(negedge clk); cmp_all(); quiet();
        urs = 1; ug = 1; arr_pre = 16'd9;
        @(negedge clk); cmp_all(); quiet();
        chk("R7 pulse", 32'(upd), 1);
        chk("R7 no flag", 32'(flag), 0);
        chk("R4 forced reload while disabled", 32'(count), 9);
        @(negedge clk); cmp_all();
        chk("R3 single-cycle pulse", 32'(upd), 0);

        // R5 suppression: reload from active value, no pulse
        arr_buf_en = 1; upd_dis = 1; arr_pre = 16'd3; ug = 1;
        @(negedge clk); cmp_all(); quiet();
        chk("R5 no pulse", 32'(upd), 0);
        chk("R5 active value kept", 32'(count), 9);
        upd_dis = 0; urs = 0; slave_rst = 1;
        @(negedge clk); cmp_all(); quiet();
        chk("R6 slave sets flag", 32'(flag), 1);
        chk("R8 buffered load at update", 32'(count), 3);

        // R2 prescaler: ratio 3 applies after an update
        psc_pre = 16'd2; ug = 1; arr_pre = 16'd7;
        @(negedge clk); cmp_all(); quiet(); cnt_en = 1;
        repeat (3) begin @(negedge clk); cmp_all(); end
        chk("R2 one step per three clocks", 32'(count), 6);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            ug        = ($urandom % 23) == 0;
            slave_rst = ($urandom % 41) == 0;
            flag_clr  = ($urandom % 10) == 0;
            if ($urandom % 30 == 0) upd_dis = ~upd_dis;
            if ($urandom % 25 == 0) urs = ~urs;
            if ($urandom % 40 == 0) arr_buf_en = ~arr_buf_en;
            if ($urandom % 50 == 0) irq_en = ~irq_en;
            cnt_en = ($urandom % 10) != 0;
            if ($urandom % 15 == 0) arr_pre = 16'($urandom % 8);
            if ($urandom % 20 == 0) psc_pre = 16'($urandom % 4);
            @(negedge clk); cmp_all();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule